// File: doc/BRIEF.md
# Four-bit register-ALU datapath

This block is a single-cycle datapath that joins a small register file to a 4-bit arithmetic and logic unit. In every cycle it reads two registers, one as operand A and one as operand B, passes them through the unit under a 4-bit function code, and offers the result as write data for a destination register. The unit covers AND, OR, add, subtract and signed set-less-than, and can invert operand A first.

The result is written into the destination register only on a clock edge where the one-cycle advance strobe is high. The strobe is a plain enable on the single system clock, so a slow pulse generator can step the datapath at human speed without gating the clock. Register 0 holds no storage. It always reads as zero, and writing to it changes nothing. Both operands, the result and a zero flag are brought out so that surrounding display logic can show them.

Top module: `regalu_datapath`

## Requirements
- R1: While rst_n is low, and on its release, every register holds 0. With all selects and the function code at 0, opnd_a, opnd_b and result are 0 and zero is 1.
- R2: Register 0 always reads 4'h0 on both read ports. A strobed write with sel_dst = 0 leaves every register unchanged.
- R3: A register changes only at a rising clock edge where adv is 1. It then takes the value result had before that edge, and only the register selected by sel_dst (when it is nonzero) changes. When adv is 0, no register changes.
- R4: func bit 3 = 1 replaces operand A by its bitwise complement before the operation. For example, code 4'b1001 with A = B = 0 gives 4'hF.
- R5: func bit 2 = 1 negates operand B, which means B is complemented and a carry-in of 1 is added. Code 4'b0110 therefore gives A - B modulo 16.
- R6: func bits 1:0 choose the operation: 00 bitwise AND, 01 bitwise OR, 10 add modulo 16. Code 4'b0000 is A AND B, 4'b0001 is A OR B and 4'b0010 is A + B.
- R7: func bits 1:0 = 11 is set-less-than. The result is 4'b0001 when the exact signed sum of the prepared A, the prepared B and the carry-in is negative, and 4'b0000 otherwise. Code 4'b0111 thus gives 1 exactly when A < B as signed 4-bit values; for example, A = 4'hF and B = 0 gives 1.
- R8: zero is 1 exactly when result is 4'h0.
- R9: opnd_a shows the register chosen by sel_a and opnd_b the register chosen by sel_b. The two selects work independently and may name the same register.
- R10: With sel_a on a register holding 1, sel_b and sel_dst on the same register, and code 4'b0010, that register goes up by one on each strobe and wraps from 4'hF to 4'h0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every state change happens on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset that clears all registers |
| adv | input | 1 | One-cycle advance strobe that enables writeback |
| sel_a | input | 3 | Register read as operand A |
| sel_b | input | 3 | Register read as operand B |
| sel_dst | input | 3 | Register written with the result |
| func | input | 4 | Function code: bit 3 invert A, bit 2 negate B, bits 1:0 operation |
| opnd_a | output | 4 | Current operand A |
| opnd_b | output | 4 | Current operand B |
| result | output | 4 | Current result, also the write data |
| zero | output | 1 | High when result is zero |

## Verification
Some properties are checked on every cycle. Register 0 always reads zero. Registers hold their values whenever the strobe is low, and a strobed write lands the sampled data in the addressed register. The write decode is at most one-hot. Add and subtract results are checked against their operands through the inverse operation, and set-less-than never drives its upper bits. Other behaviour can only be shown by the bench's scenarios. Those scenarios sweep every pair of operand values under all sixteen function codes, check the signed comparison and the zero flag against values computed arithmetically, count a register through wrap-around, and confirm that writes to register 0 and unstrobed writes leave the stored values untouched.

// File: rtl/dp_pkg.sv
package dp_pkg;

    localparam int DP_DATA_W  = 4;
    localparam int DP_NUM_REG = 8;
    localparam int DP_FUNC_W  = 4;

    // function code field positions
    localparam int FN_INV_A = 3;
    localparam int FN_NEG_B = 2;

    typedef enum logic [1:0] {
        OP_AND = 2'b00,
        OP_OR  = 2'b01,
        OP_ADD = 2'b10,
        OP_SLT = 2'b11
    } alu_op_e;

endpackage

// File: rtl/dp_wdec.sv
module dp_wdec #(
    parameter int NREG = dp_pkg::DP_NUM_REG,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            en,
    input  logic [AW-1:0]   sel,
    output logic [NREG-1:1] hit
);

    // one line per stored register; entry 0 has no storage and no line
    for (genvar g = 1; g < NREG; g++) begin : g_line
        assign hit[g] = en && (sel == AW'(g));
    end

endmodule

// File: rtl/dp_regfile.sv
module dp_regfile #(
    parameter int DW   = dp_pkg::DP_DATA_W,
    parameter int NREG = dp_pkg::DP_NUM_REG,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_sel_a,
    input  logic [AW-1:0] rd_sel_b,
    output logic [DW-1:0] rd_data_a,
    output logic [DW-1:0] rd_data_b
);

    typedef struct packed {
        logic [NREG-1:1][DW-1:0] mem;
    } rf_state_t;

    rf_state_t       rf_d, rf_q;
    logic [NREG-1:1] hit;

    dp_wdec #(.NREG(NREG)) u_wdec (
        .en  (wr_en),
        .sel (wr_sel),
        .hit (hit)
    );

    always_comb begin
        rf_d = rf_q;
        for (int i = 1; i < NREG; i++) begin
            if (hit[i]) begin
                rf_d.mem[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_q <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    // read ports: index 0 and any unused index return zero
    always_comb begin
        rd_data_a = '0;
        rd_data_b = '0;
        for (int i = 1; i < NREG; i++) begin
            if (rd_sel_a == AW'(i)) rd_data_a = rf_q.mem[i];
            if (rd_sel_b == AW'(i)) rd_data_b = rf_q.mem[i];
        end
    end

    // ---------------- assertions ----------------
    logic          chk_wr_q;
    logic [AW-1:0] chk_sel_q;
    logic [DW-1:0] chk_dat_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_wr_q  <= 1'b0;
            chk_sel_q <= '0;
            chk_dat_q <= '0;
        end else begin
            chk_wr_q  <= wr_en && (wr_sel != '0) && (int'(wr_sel) < NREG);
            chk_sel_q <= wr_sel;
            chk_dat_q <= wr_data;
        end
    end

    p_reg0_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_sel_a == '0) |-> (rd_data_a == '0)) and ((rd_sel_b == '0) |-> (rd_data_b == '0)));

    p_hold_without_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rf_q));

    p_strobed_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        chk_wr_q |-> (rf_q.mem[chk_sel_q] == chk_dat_q));

    p_single_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

endmodule

// File: rtl/dp_alu.sv
module dp_alu #(
    parameter int DW = dp_pkg::DP_DATA_W
) (
    input  logic [dp_pkg::DP_FUNC_W-1:0] func,
    input  logic [DW-1:0]                a,
    input  logic [DW-1:0]                b,
    output logic [DW-1:0]                y,
    output logic                         zero
);
    import dp_pkg::*;

    logic [DW-1:0] a_eff, b_eff, and_v, or_v, sum_v;
    logic [DW:0]   carry;
    logic          less;
    alu_op_e       op;

    assign op       = alu_op_e'(func[1:0]);
    assign carry[0] = func[FN_NEG_B];

    // ripple bit slices shared by add, subtract and compare
    for (genvar g = 0; g < DW; g++) begin : g_slice
        assign a_eff[g]   = a[g] ^ func[FN_INV_A];
        assign b_eff[g]   = b[g] ^ func[FN_NEG_B];
        assign and_v[g]   = a_eff[g] & b_eff[g];
        assign or_v[g]    = a_eff[g] | b_eff[g];
        assign sum_v[g]   = a_eff[g] ^ b_eff[g] ^ carry[g];
        assign carry[g+1] = and_v[g] | (carry[g] & (a_eff[g] ^ b_eff[g]));
    end

    // sign of the true sum: top sum bit corrected by overflow
    assign less = sum_v[DW-1] ^ carry[DW] ^ carry[DW-1];

    always_comb begin
        unique case (op)
            OP_AND:  y = and_v;
            OP_OR:   y = or_v;
            OP_ADD:  y = sum_v;
            OP_SLT:  y = {{(DW-1){1'b0}}, less};
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/regalu_datapath.sv
module regalu_datapath (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv,
    input  logic [2:0] sel_a,
    input  logic [2:0] sel_b,
    input  logic [2:0] sel_dst,
    input  logic [3:0] func,
    output logic [3:0] opnd_a,
    output logic [3:0] opnd_b,
    output logic [3:0] result,
    output logic       zero
);
    localparam int DW   = dp_pkg::DP_DATA_W;
    localparam int NREG = dp_pkg::DP_NUM_REG;

    logic [DW-1:0] rd_a, rd_b, alu_y;
    logic          alu_z;

    dp_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (adv),
        .wr_sel    (sel_dst),
        .wr_data   (alu_y),
        .rd_sel_a  (sel_a),
        .rd_sel_b  (sel_b),
        .rd_data_a (rd_a),
        .rd_data_b (rd_b)
    );

    dp_alu #(.DW(DW)) u_alu (
        .func (func),
        .a    (rd_a),
        .b    (rd_b),
        .y    (alu_y),
        .zero (alu_z)
    );

    assign opnd_a = rd_a;
    assign opnd_b = rd_b;
    assign result = alu_y;
    assign zero   = alu_z;

    // ---------------- assertions ----------------
    p_sub_inverse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (func == 4'b0110) |-> (DW'(result + opnd_b) == opnd_a));

    p_add_inverse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (func == 4'b0010) |-> (DW'(result - opnd_b) == opnd_a));

    p_or_covers_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (func == 4'b0001) |-> ((result & opnd_a) == opnd_a));

    p_inv_a_disjoint_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (func == 4'b1000) |-> ((result & opnd_a) == '0));

    p_slt_upper_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (func[1:0] == 2'b11) |-> (result[DW-1:1] == '0));

endmodule

// File: tb/sim_regalu_datapath.sv
`timescale 1ns/1ps
module sim_regalu_datapath;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       adv = 1'b0;
    logic [2:0] sel_a = '0, sel_b = '0, sel_dst = '0;
    logic [3:0] func = '0;
    logic [3:0] opnd_a, opnd_b, result;
    logic       zero;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    int model [8];

    always #2.5 clk = ~clk;

    regalu_datapath u0 (
        .clk(clk), .rst_n(rst_n), .adv(adv),
        .sel_a(sel_a), .sel_b(sel_b), .sel_dst(sel_dst), .func(func),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .zero(zero)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int sgn4(input int v);
        return (v >= 8) ? v - 16 : v;
    endfunction

    function automatic int exp_alu(input int fn, input int a, input int b);
        int ae = fn[3] ? (a ^ 15) : a;
        int be = fn[2] ? (b ^ 15) : b;
        int ci = fn[2] ? 1 : 0;
        case (fn & 3)
            0: return ae & be;
            1: return ae | be;
            2: return (ae + be + ci) % 16;
            default: return ((sgn4(ae) + sgn4(be) + ci) < 0) ? 1 : 0;
        endcase
    endfunction

    function automatic string fn_tag(input int fn);
        if ((fn & 3) == 3) return "R7";
        if (fn[2]) return "R5";
        if (fn[3]) return "R4";
        return "R6";
    endfunction

    // drive one cycle, check the combinational outputs, update the model on the edge
    task automatic step(input int sa, input int sb, input int sd, input int fn, input bit st);
        int e;
        @(negedge clk);
        sel_a = 3'(sa); sel_b = 3'(sb); sel_dst = 3'(sd); func = 4'(fn); adv = st;
        #1;
        e = exp_alu(fn, model[sa], model[sb]);
        check(opnd_a == 4'(model[sa]), "R9 opnd_a", opnd_a, model[sa]);
        check(opnd_b == 4'(model[sb]), "R9 opnd_b", opnd_b, model[sb]);
        check(result == 4'(e), fn_tag(fn), result, e);
        check(zero == (e == 0), "R8 zero", zero, e == 0);
        @(posedge clk);
        if (st && sd != 0) model[sd] = e;
    endtask

    task automatic idle();
        @(negedge clk);
        adv = 1'b0;
    endtask

    // clear a register, then count it up from register 1 (holds +1)
    task automatic load(input int r, input int v);
        step(0, 0, r, 4'b0000, 1'b1);
        for (int k = 0; k < v; k++) step(1, r, r, 4'b0010, 1'b1);
        idle();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; adv = 1'b0;
        sel_a = '0; sel_b = '0; sel_dst = '0; func = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) model[i] = 0;
    endtask

    initial begin
        do_reset();
        // R1: reset state on every register and on the outputs
        #1;
        check(opnd_a == 0 && opnd_b == 0 && result == 0, "R1 outputs", {opnd_a, opnd_b, result}, 0);
        check(zero == 1'b1, "R1 zero", zero, 1);
        for (int r = 0; r < 8; r++) step(r, r, 0, 0, 1'b0);

        // R4: invert A of register 0 gives F, store in r5
        step(0, 0, 5, 4'b1001, 1'b1);
        idle();
        step(5, 0, 0, 4'b0000, 1'b0);
        check(opnd_a == 4'hF, "R4 r5 holds F", opnd_a, 15);
        // R7: -1 less than 0 gives +1, written to r1
        step(5, 0, 1, 4'b0111, 1'b1);
        idle();
        step(1, 1, 0, 4'b0000, 1'b0);
        check(opnd_a == 4'h1, "R7 r1 holds 1", opnd_a, 1);

        // R2: strobed write to register 0 is dropped
        step(5, 0, 0, 4'b1001, 1'b1);
        idle();
        step(0, 0, 0, 4'b0000, 1'b0);
        check(opnd_a == 0 && opnd_b == 0, "R2 reg0 zero", opnd_a, 0);
        for (int r = 1; r < 8; r++) step(r, r, 0, 0, 1'b0);

        // R3: unstrobed cycles leave r5 alone
        for (int k = 0; k < 4; k++) step(1, 1, 5, 4'b0010, 1'b0);
        step(5, 5, 0, 0, 1'b0);
        check(opnd_a == 4'hF, "R3 no write without adv", opnd_a, 15);

        // R10: counter through wrap-around
        load(4, 0);
        for (int k = 0; k < 20; k++) step(1, 4, 4, 4'b0010, 1'b1);
        idle();
        step(4, 4, 0, 0, 1'b0);
        check(opnd_a == 4'h4, "R10 count 20 wraps to 4", opnd_a, 4);

        // R9: distinct values in r2..r7, every pair of read selects
        for (int r = 2; r < 8; r++) load(r, r + 7);
        for (int x = 0; x < 8; x++)
            for (int y = 0; y < 8; y++) step(x, y, 0, 0, 1'b0);

        // R4..R8: every A, every B, every function code
        for (int a = 0; a < 16; a++) begin
            load(2, a);
            for (int b = 0; b < 16; b++) begin
                load(3, b);
                for (int fn = 0; fn < 16; fn++) step(2, 3, 0, fn, 1'b0);
            end
        end

        // R1: a second reset clears stored values
        do_reset();
        for (int r = 0; r < 8; r++) begin
            @(negedge clk);
            sel_a = 3'(r); sel_b = 3'(r); func = 4'b0001;
            #1;
            check(opnd_a == 0 && opnd_b == 0, "R1 cleared after reset", opnd_a, 0);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule